// File: doc/BRIEF.md
# Delay-Coupled Two-Node Spiking Network

This block holds two excitable spiking nodes connected by clocked delay lines. Each node has a feedback link that returns its own spike train after `FB_DELAY` cycles, and a coupling link that carries its spikes to the other node after `CPL_DELAY` cycles. A node's drive is the OR of three signals: its own delayed spikes, the other node's delayed spikes, and an external stimulus bit.

A node fires on the rising edge of its drive, gated by its refractory state. When it fires it emits a pulse of fixed width and then ignores its drive for a fixed refractory window. Once the network is seeded with a single stimulus pulse, it settles into self-sustained spike trains. The ratio of the feedback delay to the coupling delay alone sets the period of those trains and whether the two nodes spike together or alternately.

Each node needs one cycle to turn a drive edge into a spike. The effective loop lengths are therefore `FB_DELAY+1` and `CPL_DELAY+1`.

Top module: `spike_pair_net`

## Requirements
- R1: A synchronous reset clears both spike outputs, the refractory state and every delay line. With no stimulus after reset, no spike appears.
- R2: The drive of node j is the OR of node j's spikes delayed by exactly `FB_DELAY` cycles, the other node's spikes delayed by exactly `CPL_DELAY` cycles, and `stimIn[j]`. A node reached only through coupling fires on the cycle the delayed spike arrives.
- R3: A node fires in the cycle its gated drive (drive AND NOT refractory) goes from 0 to 1. Its spike output rises one cycle later and stays high for exactly `PULSE_W` cycles, however long the drive stays high.
- R4: After firing, a node is refractory for `REF_W` cycles and ignores any drive during that time. If the drive is still high when the window ends, the node fires again. A constant drive therefore yields one spike every `REF_W+1` cycles.
- R5: With all delay lines empty and `stimIn` held at 0, both outputs stay at 0.
- R6: With `FB_DELAY == CPL_DELAY`, a one-cycle stimulus on one node gives both nodes in-phase trains with a period of `FB_DELAY+1` cycles.
- R7: With `FB_DELAY+1 == 2*(CPL_DELAY+1)`, a one-cycle stimulus on one node gives anti-phase trains. Each node has a period of `FB_DELAY+1` cycles, and the two nodes are offset by `CPL_DELAY+1` cycles.
- R8: When `REF_W` exceeds the longest loop plus `PULSE_W`, each returning spike arrives during the refractory window. Each node spikes once and activity then stops.
- R9: Two stimulus pulses seeded close together on one node give trains whose spike-to-spike interval is shorter than one loop period. Spikes two apart still repeat at the loop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stimIn | input | 2 | External stimulus bit per node (bit 0 is node 0) |
| spikeOut | output | 2 | Spike output per node (bit 0 is node 0) |

## Verification
Three instances run side by side: equal feedback and coupling delays, feedback loop twice the coupling loop, and a refractory window longer than every loop. Each is fed four patterns: silence, a single one-cycle seed, two seeds five cycles apart, and a long constant stimulus. The single seed separates in-phase from anti-phase locking and measures the period. It also shows the node reached only through coupling firing on the arrival cycle, and the long-refractory instance dying out. The double seed shows a train with shorter intervals. The constant stimulus measures the refractory-limited rate and the fixed pulse width. A reset taken while trains are running shows that the delay lines are really emptied.

// File: rtl/spike_pair_pkg.sv
package spike_pair_pkg;
  localparam int NODES = 2;

  typedef struct packed {
    logic [NODES-1:0] fire;
  } spkStrobe_t;
endpackage

// File: rtl/spike_delay_line.sv
module spike_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stages;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stages <= '0;
        else     stages <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stages <= '0;
        else     stages <= {stages[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = stages[DEPTH-1];
endmodule

// File: rtl/spike_pair_ctrl.sv
import spike_pair_pkg::*;

module spike_pair_ctrl (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] stimIn,
  input  logic [NODES-1:0] selfDly,
  input  logic [NODES-1:0] crossDly,
  input  logic [NODES-1:0] refBusy,
  output spkStrobe_t       strobe
);
  logic [NODES-1:0] nodeIn;
  logic [NODES-1:0] gateNow;
  logic [NODES-1:0] gatePrev;

  generate
    for (genvar j = 0; j < NODES; j++) begin : g_node
      localparam int OTH = NODES - 1 - j;
      assign nodeIn[j]  = selfDly[j] | crossDly[OTH] | stimIn[j];
      assign gateNow[j] = nodeIn[j] & ~refBusy[j];

      // a fire strobe is a single-cycle event per gated edge
      AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        strobe.fire[j] |=> !strobe.fire[j]); // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) gatePrev <= '0;
    else     gatePrev <= gateNow;
  end

  assign strobe.fire = gateNow & ~gatePrev;
endmodule

// File: rtl/spike_pair_dp.sv
import spike_pair_pkg::*;

module spike_pair_dp #(
  parameter int FB_DELAY  = 19,
  parameter int CPL_DELAY = 9,
  parameter int PULSE_W   = 2,
  parameter int REF_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  spkStrobe_t       strobe,
  output logic [NODES-1:0] spikeOut,
  output logic [NODES-1:0] refBusy,
  output logic [NODES-1:0] selfDly,
  output logic [NODES-1:0] crossDly
);
  localparam int CNT_MAX = (PULSE_W > REF_W) ? PULSE_W : REF_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_W);
  localparam logic [CNT_W-1:0] REF_LD   = CNT_W'(REF_W);

  generate
    for (genvar j = 0; j < NODES; j++) begin : g_node
      logic [CNT_W-1:0] pulseCnt;
      logic [CNT_W-1:0] refCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          pulseCnt <= '0;
          refCnt   <= '0;
        end else if (strobe.fire[j]) begin
          pulseCnt <= PULSE_LD;
          refCnt   <= REF_LD;
        end else begin
          if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
          if (refCnt != '0)   refCnt   <= refCnt - 1'b1;
        end
      end

      assign spikeOut[j] = (pulseCnt != '0);
      assign refBusy[j]  = (refCnt != '0);

      spike_delay_line #(.DEPTH(FB_DELAY)) i_fbLine (
        .clk (clk),
        .rst (rst),
        .din (spikeOut[j]),
        .dout(selfDly[j])
      );

      spike_delay_line #(.DEPTH(CPL_DELAY)) i_cplLine (
        .clk (clk),
        .rst (rst),
        .din (spikeOut[j]),
        .dout(crossDly[j])
      );

      AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !spikeOut[j] && !refBusy[j]); // R1

      AST_SPIKE_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
        strobe.fire[j] |=> spikeOut[j] && refBusy[j]); // R3

      AST_NO_FIRE_REFRACT: assert property (@(posedge clk) disable iff (rst)
        refBusy[j] |-> !strobe.fire[j]); // R4
    end
  endgenerate
endmodule

// File: rtl/spike_pair_net.sv
import spike_pair_pkg::*;

module spike_pair_net #(
  parameter int FB_DELAY  = 19,
  parameter int CPL_DELAY = 9,
  parameter int PULSE_W   = 2,
  parameter int REF_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] stimIn,
  output logic [1:0] spikeOut
);
  spkStrobe_t       strobe;
  logic [NODES-1:0] refBusy;
  logic [NODES-1:0] selfDly;
  logic [NODES-1:0] crossDly;

  spike_pair_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stimIn  (stimIn),
    .selfDly (selfDly),
    .crossDly(crossDly),
    .refBusy (refBusy),
    .strobe  (strobe)
  );

  spike_pair_dp #(
    .FB_DELAY (FB_DELAY),
    .CPL_DELAY(CPL_DELAY),
    .PULSE_W  (PULSE_W),
    .REF_W    (REF_W)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .spikeOut(spikeOut),
    .refBusy (refBusy),
    .selfDly (selfDly),
    .crossDly(crossDly)
  );
endmodule

// File: tb/test_spike_pair_net.sv
`timescale 1ns/1ps

module test_spike_pair_net;
  localparam int RING = 1024;
  localparam int MAXR = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] stim = 2'b00;
  logic [1:0] spk [3];

  int cfgK[3] = '{11, 19, 8};
  int cfgC[3] = '{11, 9, 8};
  int cfgP[3] = '{2, 2, 2};
  int cfgR[3] = '{4, 4, 20};

  bit hist [3][2][RING];
  int mPulse [3][2];
  int mRef [3][2];
  bit mPrev [3][2];
  int riseT [3][2][MAXR];
  int riseN [3][2];
  bit lastOut [3][2];
  int cyc;
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spike_pair_net #(.FB_DELAY(11), .CPL_DELAY(11), .PULSE_W(2), .REF_W(4)) i_spike_pair_net (
    .clk(clk), .rst(rst), .stimIn(stim), .spikeOut(spk[0]));
  spike_pair_net #(.FB_DELAY(19), .CPL_DELAY(9), .PULSE_W(2), .REF_W(4)) i_spike_pair_net_anti (
    .clk(clk), .rst(rst), .stimIn(stim), .spikeOut(spk[1]));
  spike_pair_net #(.FB_DELAY(8), .CPL_DELAY(8), .PULSE_W(2), .REF_W(20)) i_spike_pair_net_refr (
    .clk(clk), .rst(rst), .stimIn(stim), .spikeOut(spk[2]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clearModel();
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 2; j++) begin
        mPulse[s][j] = 0; mRef[s][j] = 0; mPrev[s][j] = 0;
        riseN[s][j] = 0; lastOut[s][j] = 0;
        for (int k = 0; k < RING; k++) hist[s][j][k] = 0;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; stim = 2'b00;
    repeat (3) @(negedge clk);
    clearModel();
    rst = 1'b0;
    cyc = 0;
  endtask

  // one cycle: compare, record, apply stimulus, advance model (R2 R3 R4 trace)
  task automatic step(input logic [1:0] st);
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 2; j++) begin
        bit expv;
        bit act;
        expv = (mPulse[s][j] != 0);
        act = spk[s][j];
        chk(act == expv, $sformatf("R2/R3/R4 trace s%0d node%0d", s, j), act, expv);
        if (act && !lastOut[s][j]) begin
          if (riseN[s][j] < MAXR) riseT[s][j][riseN[s][j]] = cyc;
          riseN[s][j]++;
        end
        lastOut[s][j] = act;
        hist[s][j][cyc % RING] = expv;
      end
    end
    stim = st;
    for (int s = 0; s < 3; s++) begin
      bit g [2];
      bit f [2];
      for (int j = 0; j < 2; j++) begin
        bit fb;
        bit cp;
        fb = (cyc >= cfgK[s]) ? hist[s][j][(cyc - cfgK[s]) % RING] : 1'b0;
        cp = (cyc >= cfgC[s]) ? hist[s][1-j][(cyc - cfgC[s]) % RING] : 1'b0;
        g[j] = (fb | cp | st[j]) && (mRef[s][j] == 0);
        f[j] = g[j] && !mPrev[s][j];
      end
      for (int j = 0; j < 2; j++) begin
        mPrev[s][j] = g[j];
        if (f[j]) begin
          mPulse[s][j] = cfgP[s];
          mRef[s][j] = cfgR[s];
        end else begin
          if (mPulse[s][j] > 0) mPulse[s][j]--;
          if (mRef[s][j] > 0) mRef[s][j]--;
        end
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  function automatic int lastRise(input int s, input int j, input int back);
    int idx;
    idx = riseN[s][j] - 1 - back;
    if (idx < 0 || idx >= MAXR) return -1000;
    return riseT[s][j][idx];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    for (int s = 0; s < 3; s++) chk(spk[s] == 2'b00, "R1 reset outputs", spk[s], 0);

    // R5 quiescent with no stimulus
    repeat (40) step(2'b00);
    for (int s = 0; s < 3; s++)
      chk(riseN[s][0] + riseN[s][1] == 0, "R5 quiescent", riseN[s][0] + riseN[s][1], 0);

    // single one-cycle seed on node 0
    doReset();
    step(2'b01);
    repeat (300) step(2'b00);
    // R2: node 1 driven only through coupling, first spike at CPL_DELAY+2
    chk(riseT[1][1][0] == 11, "R2 coupling arrival", riseT[1][1][0], 11);
    chk(riseT[0][1][0] == 13, "R2 coupling arrival equal", riseT[0][1][0], 13);
    // R6 in phase
    chk(lastRise(0,0,0) - lastRise(0,0,1) == 12, "R6 period", lastRise(0,0,0) - lastRise(0,0,1), 12);
    chk(lastRise(0,1,0) == lastRise(0,0,0), "R6 in-phase", lastRise(0,1,0), lastRise(0,0,0));
    // R7 anti phase
    chk(lastRise(1,0,0) - lastRise(1,0,1) == 20, "R7 period node0", lastRise(1,0,0) - lastRise(1,0,1), 20);
    chk(lastRise(1,1,0) - lastRise(1,1,1) == 20, "R7 period node1", lastRise(1,1,0) - lastRise(1,1,1), 20);
    chk(lastRise(1,1,0) - lastRise(1,0,0) == 10, "R7 offset", lastRise(1,1,0) - lastRise(1,0,0), 10);
    // R8 dies out
    chk(riseN[2][0] == 1, "R8 single spike node0", riseN[2][0], 1);
    chk(riseN[2][1] == 1, "R8 single spike node1", riseN[2][1], 1);

    // R1 reset while trains run must empty the delay lines
    doReset();
    for (int s = 0; s < 3; s++) chk(spk[s] == 2'b00, "R1 reset mid-train", spk[s], 0);
    repeat (60) step(2'b00);
    for (int s = 0; s < 3; s++)
      chk(riseN[s][0] + riseN[s][1] == 0, "R1 lines cleared", riseN[s][0] + riseN[s][1], 0);

    // R9 two seeds five cycles apart
    doReset();
    step(2'b01);
    repeat (4) step(2'b00);
    step(2'b01);
    repeat (200) step(2'b00);
    chk(riseT[0][0][1] - riseT[0][0][0] == 5, "R9 short interval", riseT[0][0][1] - riseT[0][0][0], 5);
    chk(riseT[0][0][2] - riseT[0][0][0] == 12, "R9 loop period", riseT[0][0][2] - riseT[0][0][0], 12);

    // R4 constant stimulus, refractory-limited rate; R3 fixed width via trace
    doReset();
    repeat (100) step(2'b10);
    chk(riseT[2][1][1] - riseT[2][1][0] == 21, "R4 constant-drive rate", riseT[2][1][1] - riseT[2][1][0], 21);
    chk(riseT[2][1][2] - riseT[2][1][1] == 21, "R4 constant-drive rate", riseT[2][1][2] - riseT[2][1][1], 21);
    chk(riseT[0][1][1] - riseT[0][1][0] == 5, "R4 constant-drive rate short", riseT[0][1][1] - riseT[0][1][0], 5);
    repeat (150) step(2'b00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule